// File: doc/BRIEF.md
# Slotted Burst Transmit Sequencer

This block sits between a host and the modulator of a slotted burst modem. The host fills a group of write registers, then posts a task code on a one-deep command register. A task can restart the transmit buffer with one group of words, append another group, arm a burst, or abort. An armed burst waits for the next slot tick. At that tick the block either starts sending buffered words toward the modulator or, when carrier-sense mode is on and a carrier is present, abandons the slot.

The modulator side is a word stream with valid/ready. `mod_valid` rises only while a burst is running and words remain. Once raised, `mod_valid` and `mod_data` hold until `mod_ready` is seen high at a clock edge, so the modulator may stall for any number of cycles. A host abort is the only event that withdraws a word already offered. `tx_en` marks the on-air window for the RF circuits. Burst completion and both kinds of abort are reported through a done flag, which also drives an interrupt, and a 3-bit state code.

Top module: `burst_tx_seq`

## Requirements
- R1: A task written with `cmd_valid` is accepted only while `cmd_free` is 1. `cmd_free` is then 0 for exactly one cycle and the task executes at the next edge. A write while `cmd_free` is 0 is dropped. Codes 0 and 5 to 7 do nothing.
- R2: Task code 1 (restart load) empties the buffer and stores the GROUP_N words of `wr_words`, lane 0 (bits DATA_W-1:0) first. It is ignored while a burst is pending or running, and while the load lock of R3 is set.
- R3: Task code 2 (append) stores one more group after the words already held. If that would exceed DEPTH words, nothing is stored and `load_ok` drops to 0. It stays 0 until an abort, and while it is 0 every load task is ignored.
- R4: Task code 3 (arm) from any state other than pending or running, with a non-empty buffer, sets `tx_state` to 1 (pending) and `buf_free` to 0. It is ignored otherwise.
- R5: A pending burst stays pending until a cycle with `slot_tick` high. At that edge, unless R7 applies, `tx_state` becomes 2 (running) and `tx_en` rises.
- R6: While running, buffered words are offered on `mod_data` in load order and held under back-pressure. At the edge that accepts the last word, `tx_state` becomes 3, `tx_en` falls, `tx_done` sets and the buffer becomes empty.
- R7: If `cs_mode` and `carrier_det` are both high at the slot tick, `tx_state` becomes 4 and `tx_done` sets, and `tx_en` never rises. The buffer is kept, so a later arm sends the same words.
- R8: With `cs_mode` low, `carrier_det` has no effect.
- R9: Task code 4 (abort) empties the buffer and clears the load lock. From pending or running it sets `tx_state` to 5, drops `tx_en` and sets `tx_done`. From any other state it sets `tx_state` to 0.
- R10: `irq` equals `tx_done` AND `irq_en`. `tx_done` clears when the next task is accepted, unless a done event happens in the same cycle.
- R11: After reset, `tx_state` is 0, `tx_en`, `tx_done`, `irq` and `mod_valid` are 0, and `cmd_free`, `load_ok` and `buf_free` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_words | input | GROUP_N*DATA_W | Host write registers, lane 0 in the low bits |
| cmd_valid | input | 1 | Task write strobe |
| cmd_code | input | 3 | Task code |
| cmd_free | output | 1 | Command register can take a task |
| load_ok | output | 1 | Load tasks are allowed (no overflow lock) |
| buf_free | output | 1 | No burst is pending or running |
| irq_en | input | 1 | Interrupt enable |
| cs_mode | input | 1 | Carrier-sense slot mode |
| carrier_det | input | 1 | Carrier present on channel |
| slot_tick | input | 1 | Slot start event, one cycle |
| tx_state | output | 3 | 0 idle, 1 pending, 2 running, 3 done, 4 carrier abort, 5 host abort |
| tx_done | output | 1 | Burst finished or aborted |
| irq | output | 1 | Interrupt request |
| tx_en | output | 1 | Transmitter enable window |
| mod_valid | output | 1 | Word offered to modulator |
| mod_ready | input | 1 | Modulator takes the word |
| mod_data | output | DATA_W | Offered word |

## Verification
The bench builds the block with DEPTH 16, GROUP_N 4 and DATA_W 16. With these values four groups fill the buffer exactly and the fifth append overflows, so the overflow lock, its blocking of further loads and its release by abort are reached in a few tasks. A full-buffer burst then drains sixteen words under a pseudo-random ready pattern. The default depth of 64 would need four times as many loads to reach the same boundary without exercising anything new.

// File: rtl/burst_tx_pkg.sv
package burst_tx_pkg;
  typedef enum logic [2:0] {
    TXS_IDLE     = 3'd0,
    TXS_PEND     = 3'd1,
    TXS_RUN      = 3'd2,
    TXS_OK       = 3'd3,
    TXS_ABT_CS   = 3'd4,
    TXS_ABT_HOST = 3'd5
  } txs_e;

  localparam logic [2:0] TASK_NOP      = 3'd0;
  localparam logic [2:0] TASK_LOAD_RST = 3'd1;
  localparam logic [2:0] TASK_LOAD_APP = 3'd2;
  localparam logic [2:0] TASK_ARM      = 3'd3;
  localparam logic [2:0] TASK_ABORT    = 3'd4;
endpackage

// File: rtl/tx_cmd_reg.sv
module tx_cmd_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  output logic       cmd_free,
  output logic       accepted,
  output logic       exec_valid,
  output logic [2:0] exec_code
);
  logic       busy_q;
  logic [2:0] code_q;

  assign accepted   = cmd_valid & ~busy_q;
  assign cmd_free   = ~busy_q;
  assign exec_valid = busy_q;
  assign exec_code  = code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      code_q <= 3'd0;
    end else if (accepted) begin
      busy_q <= 1'b1;
      code_q <= cmd_code;
    end else begin
      busy_q <= 1'b0;
    end
  end

  AST_CMD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |=> !cmd_free); // R1
  AST_CMD_RECOVERS: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_free |=> cmd_free); // R1
endmodule

// File: rtl/tx_word_buf.sv
module tx_word_buf #(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 64,
  parameter int GROUP_N = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [GROUP_N*DATA_W-1:0] grp_data,
  input  logic                      ld_first,
  input  logic                      ld_append,
  input  logic                      flush,
  input  logic                      rewind,
  input  logic                      advance,
  output logic [CW-1:0]             count,
  output logic [CW-1:0]             rd_ptr,
  output logic [DATA_W-1:0]         rd_word,
  output logic                      room
);
  localparam logic [CW:0] GRP_EXT = (CW+1)'(GROUP_N);
  localparam logic [CW:0] DEP_EXT = (CW+1)'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] lane [GROUP_N];
  logic [AW-1:0]     wbase;
  logic              wr_en;

  for (genvar g = 0; g < GROUP_N; g++) begin : g_lane
    assign lane[g] = grp_data[g*DATA_W +: DATA_W];
  end

  assign room    = ({1'b0, count} + GRP_EXT) <= DEP_EXT;
  assign wr_en   = ld_first | (ld_append & room);
  assign wbase   = ld_first ? '0 : count[AW-1:0];
  assign rd_word = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      for (int g = 0; g < GROUP_N; g++) begin
        mem[wbase + AW'(g)] <= lane[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (flush) begin
      count <= '0;
    end else if (ld_first) begin
      count <= CW'(GROUP_N);
    end else if (ld_append && room) begin
      count <= count + CW'(GROUP_N);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
    end else if (flush || rewind) begin
      rd_ptr <= '0;
    end else if (advance) begin
      rd_ptr <= rd_ptr + CW'(1);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R3
  AST_RD_BEHIND: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr <= count); // R6
endmodule

// File: rtl/tx_burst_fsm.sv
module tx_burst_fsm
  import burst_tx_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_valid,
  input  logic [2:0]    exec_code,
  input  logic          accepted,
  input  logic          slot_tick,
  input  logic          cs_mode,
  input  logic          carrier_det,
  input  logic          irq_en,
  input  logic [CW-1:0] buf_count,
  input  logic [CW-1:0] rd_ptr,
  input  logic          room,
  input  logic          mod_ready,
  output logic          mod_valid,
  output logic          ld_first,
  output logic          ld_append,
  output logic          flush,
  output logic          rewind,
  output logic          advance,
  output logic [2:0]    tx_state,
  output logic          tx_en,
  output logic          tx_done,
  output logic          irq,
  output logic          load_ok,
  output logic          buf_free
);
  txs_e state_q, state_d;
  logic tx_en_q, done_q, lock_q;
  logic active, do_abort, loads_open, start, ovf_hit;
  logic slot_hit, cs_block, handshake, last;

  assign active     = (state_q == TXS_PEND) || (state_q == TXS_RUN);
  assign do_abort   = exec_valid && (exec_code == TASK_ABORT);
  assign loads_open = exec_valid && !active && !lock_q;
  assign ld_first   = loads_open && (exec_code == TASK_LOAD_RST);
  assign ld_append  = loads_open && (exec_code == TASK_LOAD_APP);
  assign ovf_hit    = ld_append && !room;
  assign start      = exec_valid && !active && (exec_code == TASK_ARM) && (buf_count != '0);
  assign slot_hit   = (state_q == TXS_PEND) && slot_tick && !do_abort;
  assign cs_block   = cs_mode && carrier_det;
  assign mod_valid  = (state_q == TXS_RUN) && (rd_ptr < buf_count);
  assign handshake  = mod_valid && mod_ready && !do_abort;
  assign last       = handshake && ((rd_ptr + CW'(1)) == buf_count);
  assign advance    = handshake;
  assign rewind     = start;
  assign flush      = do_abort || last;

  always_comb begin
    state_d = state_q;
    if (do_abort) begin
      state_d = active ? TXS_ABT_HOST : TXS_IDLE;
    end else if (start) begin
      state_d = TXS_PEND;
    end else if (slot_hit) begin
      state_d = cs_block ? TXS_ABT_CS : TXS_RUN;
    end else if (last) begin
      state_d = TXS_OK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TXS_IDLE;
      tx_en_q <= 1'b0;
      done_q  <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (do_abort || last) begin
        tx_en_q <= 1'b0;
      end else if (slot_hit && !cs_block) begin
        tx_en_q <= 1'b1;
      end
      if ((do_abort && active) || (slot_hit && cs_block) || last) begin
        done_q <= 1'b1;
      end else if (accepted) begin
        done_q <= 1'b0;
      end
      if (do_abort) begin
        lock_q <= 1'b0;
      end else if (ovf_hit) begin
        lock_q <= 1'b1;
      end
    end
  end

  assign tx_state = state_q;
  assign tx_en    = tx_en_q;
  assign tx_done  = done_q;
  assign irq      = done_q & irq_en;
  assign load_ok  = ~lock_q;
  assign buf_free = ~active;

  AST_PEND_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TXS_PEND && !slot_tick && !do_abort) |=> state_q == TXS_PEND); // R5
  AST_TXEN_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en_q |-> state_q == TXS_RUN); // R5
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_valid && !mod_ready && !do_abort) |=> mod_valid); // R6
  AST_END_REPORTS: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (done_q && state_q == TXS_OK && !tx_en_q)); // R6
  AST_CS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TXS_ABT_CS) |-> !tx_en_q); // R7
  AST_CS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_hit && cs_block) |=> buf_count == $past(buf_count)); // R7
  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> !ld_first); // R3
endmodule

// File: rtl/burst_tx_seq.sv
module burst_tx_seq
  import burst_tx_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 64,
  parameter int GROUP_N = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [GROUP_N*DATA_W-1:0] wr_words,
  input  logic                      cmd_valid,
  input  logic [2:0]                cmd_code,
  output logic                      cmd_free,
  output logic                      load_ok,
  output logic                      buf_free,
  input  logic                      irq_en,
  input  logic                      cs_mode,
  input  logic                      carrier_det,
  input  logic                      slot_tick,
  output logic [2:0]                tx_state,
  output logic                      tx_done,
  output logic                      irq,
  output logic                      tx_en,
  output logic                      mod_valid,
  input  logic                      mod_ready,
  output logic [DATA_W-1:0]         mod_data
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          accepted, exec_valid;
  logic [2:0]    exec_code;
  logic [CW-1:0] buf_count, rd_ptr;
  logic          room, ld_first, ld_append, flush, rewind, advance;

  tx_cmd_reg u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .cmd_free   (cmd_free),
    .accepted   (accepted),
    .exec_valid (exec_valid),
    .exec_code  (exec_code)
  );

  tx_word_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH), .GROUP_N(GROUP_N)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .grp_data  (wr_words),
    .ld_first  (ld_first),
    .ld_append (ld_append),
    .flush     (flush),
    .rewind    (rewind),
    .advance   (advance),
    .count     (buf_count),
    .rd_ptr    (rd_ptr),
    .rd_word   (mod_data),
    .room      (room)
  );

  tx_burst_fsm #(.CW(CW)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .exec_valid  (exec_valid),
    .exec_code   (exec_code),
    .accepted    (accepted),
    .slot_tick   (slot_tick),
    .cs_mode     (cs_mode),
    .carrier_det (carrier_det),
    .irq_en      (irq_en),
    .buf_count   (buf_count),
    .rd_ptr      (rd_ptr),
    .room        (room),
    .mod_ready   (mod_ready),
    .mod_valid   (mod_valid),
    .ld_first    (ld_first),
    .ld_append   (ld_append),
    .flush       (flush),
    .rewind      (rewind),
    .advance     (advance),
    .tx_state    (tx_state),
    .tx_en       (tx_en),
    .tx_done     (tx_done),
    .irq         (irq),
    .load_ok     (load_ok),
    .buf_free    (buf_free)
  );

  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_valid && !mod_ready && !(exec_valid && exec_code == TASK_ABORT)) |=> $stable(mod_data)); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (tx_done && irq_en)); // R10
endmodule

// File: tb/sim_burst_tx_seq.sv
module sim_burst_tx_seq;
  localparam int DW = 16;
  localparam int GN = 4;
  localparam int DEP = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n = 1'b0;
  logic [GN*DW-1:0] wr_words = '0;
  logic           cmd_valid = 1'b0;
  logic [2:0]     cmd_code = 3'd0;
  logic           irq_en = 1'b0, cs_mode = 1'b0, carrier_det = 1'b0, slot_tick = 1'b0;
  logic           mod_ready = 1'b1;
  logic           cmd_free, load_ok, buf_free, tx_done, irq, tx_en, mod_valid;
  logic [2:0]     tx_state;
  logic [DW-1:0]  mod_data;

  burst_tx_seq #(.DATA_W(DW), .DEPTH(DEP), .GROUP_N(GN)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_words(wr_words), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_free(cmd_free), .load_ok(load_ok), .buf_free(buf_free),
    .irq_en(irq_en), .cs_mode(cs_mode), .carrier_det(carrier_det), .slot_tick(slot_tick),
    .tx_state(tx_state), .tx_done(tx_done), .irq(irq), .tx_en(tx_en),
    .mod_valid(mod_valid), .mod_ready(mod_ready), .mod_data(mod_data)
  );

  int tests = 0, fails = 0;
  logic [7:0] lf = 8'h5a;
  bit rdy_rand = 1'b0;
  bit rdy_hold = 1'b1;
  logic [DW-1:0] rx[$];

  // behavioural reference model
  int m_state, m_rd, m_cmd;
  bit m_lock, m_busy, m_done, m_txen;
  logic [DW-1:0] m_q[$];

  task automatic cmp(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_rd = 0; m_cmd = 0; m_lock = 0; m_busy = 0; m_done = 0; m_txen = 0;
      m_q.delete();
    end else begin
      bit ex, act, abrt, hs, acc, dset;
      int code, s0;
      ex = m_busy; code = m_cmd; s0 = m_state;
      act = (s0 == 1) || (s0 == 2);
      abrt = ex && (code == 4);
      hs = (s0 == 2) && (m_rd < m_q.size()) && mod_ready && !abrt;
      if (mod_valid && mod_ready) rx.push_back(mod_data);
      acc = cmd_valid && !m_busy;
      if (acc) begin m_busy = 1; m_cmd = int'(cmd_code); end else m_busy = 0;
      dset = 0;
      if (abrt) begin
        m_q.delete(); m_lock = 0; m_rd = 0;
        if (act) begin m_state = 5; m_txen = 0; dset = 1; end else m_state = 0;
      end else begin
        if (ex && !act) begin
          if (code == 1 && !m_lock) begin
            m_q.delete();
            for (int g = 0; g < GN; g++) m_q.push_back(wr_words[g*DW +: DW]);
          end else if (code == 2 && !m_lock) begin
            if (m_q.size() + GN > DEP) m_lock = 1;
            else for (int g = 0; g < GN; g++) m_q.push_back(wr_words[g*DW +: DW]);
          end else if (code == 3 && m_q.size() > 0) begin
            m_state = 1; m_rd = 0;
          end
        end
        if (s0 == 1 && slot_tick) begin
          if (cs_mode && carrier_det) begin m_state = 4; dset = 1; end
          else begin m_state = 2; m_txen = 1; end
        end else if (hs) begin
          m_rd++;
          if (m_rd == m_q.size()) begin
            m_state = 3; m_txen = 0; m_q.delete(); m_rd = 0; dset = 1;
          end
        end
      end
      if (dset) m_done = 1; else if (acc) m_done = 0;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      bit ev;
      ev = (m_state == 2) && (m_rd < m_q.size());
      cmp("R4 tx_state", int'(tx_state), m_state);
      cmp("R5 tx_en", int'(tx_en), int'(m_txen));
      cmp("R6 mod_valid", int'(mod_valid), int'(ev));
      if (ev) cmp("R6 mod_data", int'(mod_data), int'(m_q[m_rd]));
      cmp("R4 buf_free", int'(buf_free), int'(!(m_state == 1 || m_state == 2)));
      cmp("R3 load_ok", int'(load_ok), int'(!m_lock));
      cmp("R1 cmd_free", int'(cmd_free), int'(!m_busy));
      cmp("R10 tx_done", int'(tx_done), int'(m_done));
      cmp("R10 irq", int'(irq), int'(m_done && irq_en));
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    mod_ready = rdy_rand ? lf[0] : rdy_hold;
  endtask

  task automatic do_cmd(input logic [2:0] c);
    cmd_valid = 1'b1; cmd_code = c;
    step();
    cmd_valid = 1'b0;
    step();
  endtask

  task automatic load_grp(input bit first, input logic [DW-1:0] base);
    for (int g = 0; g < GN; g++) wr_words[g*DW +: DW] = base + DW'(g);
    do_cmd(first ? 3'd1 : 3'd2);
  endtask

  task automatic slot();
    slot_tick = 1'b1; step(); slot_tick = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && tx_state == 3'd2; i++) step();
  endtask

  task automatic chk_rx(input string tag, input logic [DW-1:0] base, input int n);
    cmp({tag, " rx count"}, rx.size(), n);
    for (int i = 0; i < n && i < rx.size(); i++)
      cmp({tag, " rx word"}, int'(rx[i]), int'(base) + (i % GN) + 256 * (i / GN));
  endtask

  initial begin
    #800000;
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    step(); step(); step();
    // R11 reset state
    cmp("R11 tx_state", int'(tx_state), 0);
    cmp("R11 tx_en", int'(tx_en), 0);
    cmp("R11 tx_done", int'(tx_done), 0);
    cmp("R11 mod_valid", int'(mod_valid), 0);
    cmp("R11 status", int'({cmd_free, load_ok, buf_free}), 7);
    rst_n = 1'b1;
    step();

    // R2 / R4 / R5 / R6: two groups, pending hold, random back-pressure
    irq_en = 1'b1;
    load_grp(1'b1, 16'h0100);
    load_grp(1'b0, 16'h0200);
    do_cmd(3'd3);
    cmp("R4 armed state", int'(tx_state), 1);
    load_grp(1'b1, 16'h0900);
    step(); step();
    cmp("R5 still pending", int'(tx_state), 1);
    rx.delete();
    rdy_rand = 1'b1;
    slot();
    cmp("R5 running", int'(tx_state), 2);
    cmp("R5 tx_en up", int'(tx_en), 1);
    drain();
    rdy_rand = 1'b0;
    cmp("R6 done state", int'(tx_state), 3);
    cmp("R6 tx_en down", int'(tx_en), 0);
    cmp("R10 irq raised", int'(irq), 1);
    chk_rx("R2 R6", 16'h0100, 8);

    // R10: next accepted task clears done; R4: arm on empty buffer ignored
    do_cmd(3'd0);
    cmp("R10 done cleared", int'(tx_done), 0);
    do_cmd(3'd3);
    cmp("R4 empty arm ignored", int'(tx_state), 3);

    // R7: carrier abort keeps data, re-arm sends it
    cs_mode = 1'b1; carrier_det = 1'b1;
    load_grp(1'b1, 16'h0300);
    do_cmd(3'd3);
    slot();
    cmp("R7 carrier abort", int'(tx_state), 4);
    cmp("R7 done", int'(tx_done), 1);
    cmp("R7 no tx_en", int'(tx_en), 0);
    carrier_det = 1'b0;
    rx.delete();
    do_cmd(3'd3);
    slot();
    drain();
    cmp("R7 resend done", int'(tx_state), 3);
    chk_rx("R7", 16'h0300, 4);

    // R8: carrier ignored outside carrier-sense mode
    cs_mode = 1'b0; carrier_det = 1'b1;
    load_grp(1'b1, 16'h0700);
    do_cmd(3'd3);
    slot();
    cmp("R8 runs despite carrier", int'(tx_state), 2);
    drain();
    carrier_det = 1'b0;

    // R3: overflow lock, R9 release
    load_grp(1'b1, 16'h0400);
    load_grp(1'b0, 16'h0500);
    load_grp(1'b0, 16'h0600);
    load_grp(1'b0, 16'h0700);
    cmp("R3 full buffer ok", int'(load_ok), 1);
    load_grp(1'b0, 16'h0800);
    cmp("R3 overflow locks", int'(load_ok), 0);
    load_grp(1'b1, 16'h0a00);
    rx.delete();
    do_cmd(3'd3);
    slot();
    drain();
    chk_rx("R3", 16'h0400, 16);
    cmp("R3 lock persists", int'(load_ok), 0);
    do_cmd(3'd4);
    cmp("R9 lock cleared", int'(load_ok), 1);
    cmp("R9 idle abort", int'(tx_state), 0);

    // R9: host abort while running under stall
    load_grp(1'b1, 16'h0b00);
    do_cmd(3'd3);
    rdy_hold = 1'b0;
    slot();
    step(); step();
    do_cmd(3'd4);
    rdy_hold = 1'b1;
    cmp("R9 host abort", int'(tx_state), 5);
    cmp("R9 tx_en off", int'(tx_en), 0);
    cmp("R9 done", int'(tx_done), 1);
    do_cmd(3'd3);
    cmp("R9 buffer emptied", int'(tx_state), 5);

    // R1: back-to-back write, second dropped
    for (int g = 0; g < GN; g++) wr_words[g*DW +: DW] = 16'h0c00 + DW'(g);
    cmd_valid = 1'b1; cmd_code = 3'd1;
    step();
    cmp("R1 busy after write", int'(cmd_free), 0);
    cmd_code = 3'd4;
    step();
    cmd_valid = 1'b0;
    step();
    rx.delete();
    do_cmd(3'd3);
    slot();
    drain();
    chk_rx("R1", 16'h0c00, 4);

    step(); step();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule